// File: doc/BRIEF.md
# Fuse Array Byte-Read Sequencer

This block fetches a single byte from a one-time-programmable fuse macro. Software chooses a fuse address and issues a start command through a small 32-bit register port. The block then walks the macro's five control lines (select, program enable, load, address enable, sense strobe) through a waveform that software describes. For every line a timing register gives a start cycle and a pulse length, both counted from the first cycle of the sequence. The sensed byte is latched at the trailing edge of the strobe pulse. A finish flag then rises and the byte can be read back.

The waveform is set entirely by register contents rather than by fixed state timing, so one block can follow any macro's read timing once it has been configured. All registers come out of reset as zero, so software must load the profile before the first read. A command issued while the mode bit requests manual operation is refused. A command issued while a sequence is still running is refused as well.

Top module: `fuse_read_seq`

## Requirements
- R1: After reset the mode, status, data, control and all five timing registers read 0, and every macro control output is low.
- R2: A write to word 9 (byte offset 0x24) starts a sequence only when bits 0 and 1 are both 1 and mode register bit 0 (word 0) is 0. A write with mode bit 0 set to 1, or with only bit 0 set, leaves all outputs low and the status at 0.
- R3: Bits [25:16] of the accepted start write appear on `macroAddr` and stay unchanged for the whole sequence.
- R4: Timing words 15..19 (offsets 0x3C..0x4C) describe, in this order, select, program enable, load, address enable and strobe. Bits [31:16] give the start cycle S and bits [15:0] give the length L. Cycle 0 is the clock cycle right after the edge that accepts the start write. Each output is high exactly in the cycles S ≤ k < S+L, and it never rises when L is 0.
- R5: The timing registers read back whatever value was last written to them.
- R6: A sequence lasts E cycles, where E is the largest S+L among the lines with nonzero L, or 1 if every L is 0. Status bit 1 (word 6, offset 0x18) reads 1 during cycles 0..E-1 and 0 from cycle E on.
- R7: The value on `macroDout` in the last strobe cycle (k = S+L-1) is stored and read from bits [7:0] of word 8 (offset 0x20). If the strobe length is 0, the stored byte keeps its previous value.
- R8: Status bit 0 becomes 1 in cycle E and stays set until software writes a 1 to status bit 0.
- R9: A start write that arrives while a sequence is running is ignored: the address, the waveform and the captured byte all stay those of the running sequence.
- R10: A timing register written during a sequence has no effect on that sequence. The new value applies from the next accepted start.
- R11: Word 20 (offset 0x50) returns the REVISION parameter, and writes to it have no effect.
- R12: Read data appears on `regRdata` one clock after `regRe` is sampled, and it reflects the register state of the cycle in which the read was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write enable |
| regRe | input | 1 | Register read enable |
| regAddr | input | AW (6) | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, one cycle after regRe |
| macroSel | output | 1 | Fuse macro select |
| macroProgEn | output | 1 | Fuse macro program enable |
| macroLoad | output | 1 | Fuse macro load |
| macroAddrEn | output | 1 | Fuse macro address enable |
| macroStrobe | output | 1 | Fuse macro sense strobe |
| macroAddr | output | ADDR_W (10) | Fuse byte address |
| macroDout | input | DATA_W (8) | Sensed byte from the macro |

## Verification
The pin outputs are combinational from the sequence counter. Cycle k of a sequence is therefore visible in the half period that follows the k-th clock edge after the accepting edge. The bench samples every line on falling edges, counting from the falling edge right after the start write, and compares each sample with the S ≤ k < S+L window. A register read costs one edge: a read raised at the falling edge of cycle k returns the state of cycle k at the next falling edge. The busy-to-finish handover is checked this way, with back-to-back reads issued in cycles E-1 and E. The captured byte and the finish flag are read only after cycle E+1. Injected writes during a sequence are timed to the chosen cycle k of the same count.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  // number of macro control lines and their index in the timing bank
  localparam int NSIG     = 5;
  localparam int SIG_SEL  = 0;
  localparam int SIG_PGM  = 1;
  localparam int SIG_LOAD = 2;
  localparam int SIG_AEN  = 3;
  localparam int SIG_STB  = 4;

  // timing field width: start in the upper half, length in the lower half
  localparam int TW = 16;
  localparam int CW = TW + 1;

  // register word addresses
  localparam int WORD_MODE   = 0;
  localparam int WORD_STATUS = 6;
  localparam int WORD_DATA   = 8;
  localparam int WORD_CTRL   = 9;
  localparam int WORD_TIME0  = 15;
  localparam int WORD_REV    = 20;

  typedef struct packed {
    logic loadShadow;  // start accepted: freeze profile and address
    logic capture;     // last strobe cycle: latch sensed byte
    logic done;        // last cycle of the sequence
  } seqStrobes_t;
endpackage

// File: rtl/fuse_seq_ctl.sv
module fuse_seq_ctl
  import fuse_seq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdReq,
  input  logic [NSIG-1:0][2*TW-1:0] shadowTiming,
  output seqStrobes_t               strobes,
  output logic [NSIG-1:0]           pinWin,
  output logic                      busy,
  output logic [CW-1:0]             seqCount
);
  logic          busyQ;
  logic [CW-1:0] cntQ;
  logic [CW-1:0] sigEnd [NSIG];
  logic [NSIG-1:0] sigLive;
  logic [CW-1:0] endMax;
  logic          lastCycle;

  genvar gi;
  generate
    for (gi = 0; gi < NSIG; gi++) begin : g_win
      logic [CW-1:0] sStart;
      logic [CW-1:0] sLen;
      assign sStart      = {1'b0, shadowTiming[gi][2*TW-1:TW]};
      assign sLen        = {1'b0, shadowTiming[gi][TW-1:0]};
      assign sigEnd[gi]  = sStart + sLen;
      assign sigLive[gi] = (sLen != '0);
      assign pinWin[gi]  = busyQ && sigLive[gi] && (cntQ >= sStart) && (cntQ < sigEnd[gi]);
    end
  endgenerate

  always_comb begin
    endMax = '0;
    for (int i = 0; i < NSIG; i++) begin
      if (sigLive[i] && (sigEnd[i] > endMax)) endMax = sigEnd[i];
    end
  end

  assign lastCycle = busyQ && ((cntQ + CW'(1)) >= endMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (cmdReq && !busyQ) begin
      busyQ <= 1'b1;
      cntQ  <= '0;
    end else if (lastCycle) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      cntQ  <= cntQ + CW'(1);
    end
  end

  assign strobes.loadShadow = cmdReq && !busyQ;
  assign strobes.capture    = busyQ && sigLive[SIG_STB] && (cntQ == sigEnd[SIG_STB] - CW'(1));
  assign strobes.done       = lastCycle;
  assign busy               = busyQ;
  assign seqCount           = cntQ;
endmodule

// File: rtl/fuse_seq_dp.sv
module fuse_seq_dp
  import fuse_seq_pkg::*;
#(
  parameter int          AW       = 6,
  parameter int          ADDR_W   = 10,
  parameter int          DATA_W   = 8,
  parameter logic [31:0] REVISION = 32'h0000_0001
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWe,
  input  logic                      regRe,
  input  logic [AW-1:0]             regAddr,
  input  logic [31:0]               regWdata,
  output logic [31:0]               regRdata,
  input  seqStrobes_t               strobes,
  input  logic                      busy,
  input  logic [DATA_W-1:0]         macroDout,
  output logic                      cmdReq,
  output logic [NSIG-1:0][2*TW-1:0] shadowTiming,
  output logic [ADDR_W-1:0]         fuseAddr,
  output logic                      modeUser,
  output logic                      finish
);
  localparam int ADDR_LSB = 16;

  logic [NSIG-1:0][2*TW-1:0] liveTiming;
  logic [DATA_W-1:0]         dataQ;
  logic                      modeQ;
  logic                      finishQ;
  logic [ADDR_W-1:0]         addrQ;
  logic [31:0]               rdMux;

  assign cmdReq = regWe && (regAddr == AW'(WORD_CTRL)) && regWdata[0] && regWdata[1] && !modeQ;

  genvar gi;
  generate
    for (gi = 0; gi < NSIG; gi++) begin : g_time
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          liveTiming[gi]   <= '0;
          shadowTiming[gi] <= '0;
        end else begin
          if (regWe && (regAddr == AW'(WORD_TIME0 + gi))) liveTiming[gi] <= regWdata;
          if (strobes.loadShadow) shadowTiming[gi] <= liveTiming[gi];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      addrQ   <= '0;
      dataQ   <= '0;
      finishQ <= 1'b0;
    end else begin
      if (regWe && (regAddr == AW'(WORD_MODE))) modeQ <= regWdata[0];
      if (strobes.loadShadow) addrQ <= regWdata[ADDR_LSB +: ADDR_W];
      if (strobes.capture) dataQ <= macroDout;
      if (strobes.done) finishQ <= 1'b1;
      else if (regWe && (regAddr == AW'(WORD_STATUS)) && regWdata[0]) finishQ <= 1'b0;
    end
  end

  always_comb begin
    rdMux = '0;
    if (regAddr == AW'(WORD_MODE))   rdMux = {31'b0, modeQ};
    if (regAddr == AW'(WORD_STATUS)) rdMux = {30'b0, busy, finishQ};
    if (regAddr == AW'(WORD_DATA))   rdMux = 32'(dataQ);
    if (regAddr == AW'(WORD_CTRL))   rdMux = 32'(addrQ) << ADDR_LSB;
    if (regAddr == AW'(WORD_REV))    rdMux = REVISION;
    for (int i = 0; i < NSIG; i++) begin
      if (regAddr == AW'(WORD_TIME0 + i)) rdMux = liveTiming[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      regRdata <= '0;
    else if (regRe) regRdata <= rdMux;
  end

  assign fuseAddr = addrQ;
  assign modeUser = modeQ;
  assign finish   = finishQ;
endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_seq_pkg::*;
#(
  parameter int          AW       = 6,
  parameter int          ADDR_W   = 10,
  parameter int          DATA_W   = 8,
  parameter logic [31:0] REVISION = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [AW-1:0]     regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              macroSel,
  output logic              macroProgEn,
  output logic              macroLoad,
  output logic              macroAddrEn,
  output logic              macroStrobe,
  output logic [ADDR_W-1:0] macroAddr,
  input  logic [DATA_W-1:0] macroDout
);
  seqStrobes_t               strobes;
  logic                      cmdReq;
  logic [NSIG-1:0][2*TW-1:0] shadowTiming;
  logic [NSIG-1:0]           pinWin;
  logic                      busy;
  logic [CW-1:0]             seqCount;
  logic                      modeUser;
  logic                      finish;

  fuse_seq_dp #(
    .AW(AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REVISION(REVISION)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strobes(strobes), .busy(busy),
    .macroDout(macroDout), .cmdReq(cmdReq), .shadowTiming(shadowTiming),
    .fuseAddr(macroAddr), .modeUser(modeUser), .finish(finish)
  );

  fuse_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .shadowTiming(shadowTiming),
    .strobes(strobes), .pinWin(pinWin), .busy(busy), .seqCount(seqCount)
  );

  assign macroSel    = pinWin[SIG_SEL];
  assign macroProgEn = pinWin[SIG_PGM];
  assign macroLoad   = pinWin[SIG_LOAD];
  assign macroAddrEn = pinWin[SIG_AEN];
  assign macroStrobe = pinWin[SIG_STB];
endmodule

// File: rtl/fuse_read_seq_chk.sv
module fuse_read_seq_chk
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              finish,
  input logic              modeUser,
  input logic [CW-1:0]     seqCount,
  input logic [ADDR_W-1:0] macroAddr,
  input logic [4:0]        pins
);
  // R4: no control line is active outside a sequence
  a_r4_idle_pins_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (pins == 5'b0));

  // R3, R9: the fuse address is frozen while a sequence runs
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(macroAddr));

  // R6: the cycle counter advances by one every busy cycle
  a_r6_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (seqCount == $past(seqCount) + CW'(1)));

  // R8: the finish flag is raised by the end of a sequence
  a_r8_finish_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> finish);

  // R2: manual mode keeps the sequencer idle
  a_r2_user_mode_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (modeUser && !busy) |=> !busy);
endmodule

bind fuse_read_seq fuse_read_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .finish(finish), .modeUser(modeUser),
  .seqCount(seqCount), .macroAddr(macroAddr),
  .pins({macroStrobe, macroAddrEn, macroLoad, macroProgEn, macroSel})
);

// File: tb/test_fuse_read_seq.sv
module test_fuse_read_seq;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] REV        = 32'h0001_0203;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        macroSel, macroProgEn, macroLoad, macroAddrEn, macroStrobe;
  logic [9:0]  macroAddr;
  logic [7:0]  macroDout;

  int vectors = 0;
  int fails   = 0;
  int expS[5];
  int expL[5];

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_read_seq #(.REVISION(REV)) i_fuse_read_seq (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .macroSel(macroSel),
    .macroProgEn(macroProgEn), .macroLoad(macroLoad), .macroAddrEn(macroAddrEn),
    .macroStrobe(macroStrobe), .macroAddr(macroAddr), .macroDout(macroDout)
  );

  // behavioural fuse array: 64 bytes, output valid while the strobe is high
  function automatic logic [7:0] fuseByte(input int a);
    return 8'((a * 53 + 17) ^ (a * 4));
  endfunction
  assign macroDout = macroStrobe ? fuseByte(int'(macroAddr[5:0])) : 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int word, input logic [31:0] val);
    regWe = 1'b1; regAddr = 6'(word); regWdata = val;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input int word, output logic [31:0] val);
    regRe = 1'b1; regAddr = 6'(word);
    @(negedge clk);
    val = regRdata;
    regRe = 1'b0;
  endtask

  task automatic setTiming(input int sig, input int s, input int l);
    wr(15 + sig, (32'(s) << 16) | 32'(l));
    expS[sig] = s; expL[sig] = l;
  endtask

  function automatic int expEnd();
    int m = 0;
    for (int i = 0; i < 5; i++)
      if (expL[i] != 0 && expS[i] + expL[i] > m) m = expS[i] + expL[i];
    return (m < 1) ? 1 : m;
  endfunction

  task automatic typicalProfile();
    setTiming(0, 0, 0); setTiming(1, 0, 0); setTiming(2, 15, 50);
    setTiming(3, 24, 31); setTiming(4, 27, 37);
  endtask

  task automatic shortProfile();
    setTiming(0, 0, 3); setTiming(1, 2, 4); setTiming(2, 1, 10);
    setTiming(3, 0, 12); setTiming(4, 5, 6);
  endtask

  // start a sequence and compare every line in every cycle with its window
  task automatic runSeq(input int addr, input int injK, input int injWord,
                        input logic [31:0] injData, input string req);
    int e = expEnd();
    int bad = 0;
    int badK = 0;
    logic [4:0] badAct = '0, badExp = '0;
    wr(9, (32'(addr) << 16) | 32'd3);
    for (int k = 0; k <= e + 1; k++) begin
      logic [4:0] pins, want;
      if (k == injK) begin
        regWe = 1'b1; regAddr = 6'(injWord); regWdata = injData;
      end else if (k == injK + 1) begin
        regWe = 1'b0;
      end
      pins = {macroStrobe, macroAddrEn, macroLoad, macroProgEn, macroSel};
      for (int i = 0; i < 5; i++) want[i] = (k >= expS[i]) && (k < expS[i] + expL[i]);
      if (pins != want || (k < e && macroAddr != 10'(addr))) begin
        if (bad == 0) begin badK = k; badAct = pins; badExp = want; end
        bad++;
      end
      @(negedge clk);
    end
    regWe = 1'b0;
    if (bad != 0) $display("  first mismatch at cycle %0d", badK);
    chk(bad == 0, req, "line windows and address", badAct, badExp);
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk({macroStrobe, macroAddrEn, macroLoad, macroProgEn, macroSel} == 5'b0, "R1", "pins", 0, 0);
    rd(0, v); chk(v == 0, "R1", "mode", v, 0);
    rd(6, v); chk(v == 0, "R1", "status", v, 0);
    rd(8, v); chk(v == 0, "R1", "data", v, 0);
    rd(9, v); chk(v == 0, "R1", "control", v, 0);
    for (int i = 0; i < 5; i++) begin
      rd(15 + i, v); chk(v == 0, "R1", "timing", v, 0);
    end
  endtask

  task automatic testRegs();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin
      wr(15 + i, 32'hA5C3_0000 + 32'(i * 4097));
    end
    for (int i = 0; i < 5; i++) begin
      rd(15 + i, v); chk(v == 32'hA5C3_0000 + 32'(i * 4097), "R5", "timing readback", v, 32'hA5C3_0000 + 32'(i * 4097));
    end
    wr(20, 32'hFFFF_FFFF);
    rd(20, v); chk(v == REV, "R11", "revision", v, REV);
    // R12: a read in the cycle after a write sees the new value
    wr(15, 32'h1234_5678);
    rd(15, v); chk(v == 32'h1234_5678, "R12", "read after write", v, 32'h1234_5678);
  endtask

  task automatic testTypical();
    logic [31:0] v;
    typicalProfile();
    runSeq(5, -1, 0, 0, "R4");
    rd(9, v); chk(v == (32'd5 << 16), "R3", "control address", v, 32'd5 << 16);
    rd(6, v); chk(v == 1, "R8", "finish set", v, 1);
    rd(8, v); chk(v == 32'(fuseByte(5)), "R7", "captured byte", v, fuseByte(5));
    wr(6, 0);
    rd(6, v); chk(v == 1, "R8", "write 0 keeps flag", v, 1);
    wr(6, 1);
    rd(6, v); chk(v == 0, "R8", "write 1 clears flag", v, 0);
  endtask

  // busy in cycle E-1, finish (and not busy) in cycle E
  task automatic durationCheck(input int addr, input string req);
    int e = expEnd();
    wr(6, 1);
    wr(9, (32'(addr) << 16) | 32'd3);
    repeat (e - 1) @(negedge clk);
    regRe = 1'b1; regAddr = 6'd6;
    @(negedge clk);
    chk(regRdata[1:0] == 2'b10, req, "status in last cycle", regRdata[1:0], 2'b10);
    @(negedge clk);
    chk(regRdata[1:0] == 2'b01, req, "status after end", regRdata[1:0], 2'b01);
    regRe = 1'b0;
  endtask

  task automatic testDuration();
    logic [31:0] v;
    shortProfile();
    wr(6, 1);
    runSeq(12, -1, 0, 0, "R4");
    durationCheck(33, "R6");
    rd(8, v); chk(v == 32'(fuseByte(33)), "R7", "short profile byte", v, fuseByte(33));
    for (int i = 0; i < 5; i++) setTiming(i, 3, 0);
    durationCheck(40, "R6");
    rd(8, v); chk(v == 32'(fuseByte(33)), "R7", "zero strobe keeps byte", v, fuseByte(33));
  endtask

  task automatic testRefused();
    logic [31:0] v;
    int hits = 0;
    typicalProfile();
    wr(6, 1);
    wr(0, 1);
    rd(0, v); chk(v == 1, "R2", "mode set", v, 1);
    wr(9, (32'd4 << 16) | 32'd3);
    for (int k = 0; k < 70; k++) begin
      if ({macroStrobe, macroAddrEn, macroLoad, macroProgEn, macroSel} != 5'b0) hits++;
      @(negedge clk);
    end
    rd(6, v); chk(v == 0 && hits == 0, "R2", "manual mode refuses start", v + hits, 0);
    wr(0, 0);
    wr(9, (32'd4 << 16) | 32'd1);
    for (int k = 0; k < 70; k++) begin
      if ({macroStrobe, macroAddrEn, macroLoad, macroProgEn, macroSel} != 5'b0) hits++;
      @(negedge clk);
    end
    rd(6, v); chk(v == 0 && hits == 0, "R2", "enable without read bit", v + hits, 0);
  endtask

  task automatic testRestart();
    logic [31:0] v;
    typicalProfile();
    wr(6, 1);
    runSeq(7, 3, 9, (32'd9 << 16) | 32'd3, "R9");
    rd(8, v); chk(v == 32'(fuseByte(7)), "R9", "byte of first address", v, fuseByte(7));
    rd(6, v); chk(v == 1, "R9", "single finish, idle", v, 1);
  endtask

  task automatic testLateWrite();
    logic [31:0] v;
    shortProfile();
    wr(6, 1);
    runSeq(20, 2, 19, (32'd3 << 16) | 32'd2, "R10");
    rd(8, v); chk(v == 32'(fuseByte(20)), "R10", "byte with old profile", v, fuseByte(20));
    expS[4] = 3; expL[4] = 2;
    runSeq(21, -1, 0, 0, "R10");
    rd(8, v); chk(v == 32'(fuseByte(21)), "R10", "byte with new profile", v, fuseByte(21));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) begin expS[i] = 0; expL[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testTypical();
    testDuration();
    testRefused();
    testRestart();
    testLateWrite();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule